// File: doc/BRIEF.md
# Per-Core Redirected Register Window

This block is the configuration register space of a small multi-core cluster. A 32 KB address range is split into four 8 KB windows, picked by the top two address bits: global registers, the requester's own per-core registers, a redirected per-core window, and a debug window. Every access carries the identity of the core that issues it. The core-local window therefore always reaches that core's own bank. The redirected window reaches whatever the requester has chosen in its private selector register.

Each core's selector has three parts: a target core, a virtual-processor index, and a block field. With block value 0 the redirected window reaches the target core's per-core bank, at the same offsets as the core-local window. With value 1 it reaches the global registers. Values 2 and 3 name blocks that are not implemented. This lets one core program or inspect another core's coherence enable and selector without changing addresses. Because the selectors are private, two cores can use the redirected window at the same time without interfering.

The bus is single-cycle. Address, write enable and write data are taken on a clock edge, and read data for that request is registered on the same edge.

Top module: `cfg_redirect_space`

## Requirements
- R1: Synchronous active-low reset clears every coherence enable, every selector, the global control word and `rd_data`.
- R2: `rd_data` holds the value of the location addressed on the previous clock edge, as it stood before any write on that same edge.
- R3: `addr[14:13]` picks the window: 0 global, 1 core-local, 2 redirected, 3 debug. Debug-window reads return 0 and writes change nothing.
- R4: Per-core offset 0x008 holds the coherence enable in bit 0, is writable, and reads 0 in bits 31:1. Offset 0x028 is read-only and returns CLUSTER_ID in bits 15:8 and the core index in bits 7:0.
- R5: Per-core offset 0x018 is the selector: block in bits 25:24, target core in bits 13:8, virtual-processor index in bits 2:0. These bits are writable and read back. All other bits read 0.
- R6: With selector block 0 and a target core below NUM_CORES, a redirected-window access at offset X reads and writes the target core's per-core register at X.
- R7: With selector block 1, a redirected-window access at offset X reads and writes the global register at X.
- R8: With selector block 2 or 3, redirected-window reads return 0 and writes change nothing.
- R9: With selector block 0 and a target core at or above NUM_CORES, redirected-window reads return 0 and writes change no core's registers.
- R10: The selector used for a redirected access is the requester's own, so writing one core's selector does not change where another core's redirected accesses go.
- R11: Global offset 0x000 is read-only and returns NUM_CORES in bits 7:0. Global offset 0x008 is a 32-bit read/write control word. Unimplemented offsets in any bank read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_id | input | 6 | Index of the core issuing the access |
| addr | input | 15 | Byte address within the register space |
| wr_en | input | 1 | Write strobe for this cycle's access |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data for the previous cycle's address |

## Verification
Every result of this block is due on the first rising edge after the request is presented: read data, and the register update made by a write. The bench drives each request on a falling edge and returns the bus to an idle debug-window address one step after the next rising edge. It compares `rd_data` at the following falling edge, so each comparison sees exactly one request's answer. Requests that write while reading expect the pre-write value. The effects of a write, including writes that must be ignored, are confirmed by a later read through the core-local or global window. One directed case also checks that `rd_data` has not yet changed before the capturing edge.

// File: rtl/cfgsp_pkg.sv
// Package: shared encodings for the redirected register space.
// Assumes a 32-bit register bus and four 8 KB windows.
package cfgsp_pkg;
    localparam int WIN_OFS_W  = 13;
    localparam int ADDR_W     = WIN_OFS_W + 2;
    localparam int DATA_W     = 32;
    localparam int CORE_SEL_W = 6;

    typedef enum logic [1:0] {
        WIN_GLOBAL = 2'd0,
        WIN_LOCAL  = 2'd1,
        WIN_OTHER  = 2'd2,
        WIN_DEBUG  = 2'd3
    } win_e;

    typedef enum logic [1:0] {
        BLK_CORE      = 2'd0,
        BLK_GLOBAL    = 2'd1,
        BLK_USER      = 2'd2,
        BLK_GLOBAL_HI = 2'd3
    } blk_e;

    typedef enum logic [1:0] {
        TGT_NONE   = 2'd0,
        TGT_CORE   = 2'd1,
        TGT_GLOBAL = 2'd2
    } tgt_e;

    localparam logic [WIN_OFS_W-1:0] OFS_COH   = 13'h008;
    localparam logic [WIN_OFS_W-1:0] OFS_SEL   = 13'h018;
    localparam logic [WIN_OFS_W-1:0] OFS_ID    = 13'h028;
    localparam logic [WIN_OFS_W-1:0] OFS_GINFO = 13'h000;
    localparam logic [WIN_OFS_W-1:0] OFS_GCTL  = 13'h008;

    // Selector layout: block 25:24, target core 13:8, vp 2:0
    typedef struct packed {
        logic [5:0]            rsv_hi;
        blk_e                  blk;
        logic [9:0]            rsv_mid;
        logic [CORE_SEL_W-1:0] core;
        logic [4:0]            rsv_lo;
        logic [2:0]            vp;
    } sel_t;
endpackage

// File: rtl/cfgsp_win_decode.sv
// Module: window decoder.
// Turns an address and the requester's selector fields into a target
// (none, a core bank, or the global bank) plus a target core index.
// Assumes the in-window offset is passed on unchanged to the target.
module cfgsp_win_decode
    import cfgsp_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic [CORE_SEL_W-1:0] core_id,
    input  blk_e                  req_blk,
    input  logic [CORE_SEL_W-1:0] req_core,
    output tgt_e                  tgt,
    output logic [CORE_SEL_W-1:0] tgt_core
);
    localparam logic [CORE_SEL_W-1:0] NC = CORE_SEL_W'(NUM_CORES);

    win_e win;
    assign win = win_e'(addr[ADDR_W-1 -: 2]);

    // Resolve the window, and for the redirected window the selector, into a target
    always_comb begin
        tgt      = TGT_NONE;
        tgt_core = '0;
        case (win)
            WIN_GLOBAL: tgt = TGT_GLOBAL;
            WIN_LOCAL: begin
                if (core_id < NC) begin
                    tgt      = TGT_CORE;
                    tgt_core = core_id;
                end
            end
            WIN_OTHER: begin
                case (req_blk)
                    BLK_CORE: begin
                        if (req_core < NC) begin
                            tgt      = TGT_CORE;
                            tgt_core = req_core;
                        end
                    end
                    BLK_GLOBAL: tgt = TGT_GLOBAL;
                    default:    tgt = TGT_NONE;
                endcase
            end
            default: tgt = TGT_NONE;
        endcase
    end
endmodule

// File: rtl/cfgsp_core_regs.sv
// Module: one core's register bank.
// Holds the coherence enable and the redirection selector, and returns the
// read-only identity word. Reads are combinational; the caller registers them.
// Assumes wr_stb is already qualified for this bank.
module cfgsp_core_regs
    import cfgsp_pkg::*;
#(
    parameter int         CORE_IDX   = 0,
    parameter logic [7:0] CLUSTER_ID = 8'h00
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_stb,
    input  logic [WIN_OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [DATA_W-1:0]     rd_val,
    output blk_e                  sel_blk,
    output logic [CORE_SEL_W-1:0] sel_core
);
    localparam logic [DATA_W-1:0] SEL_MASK = 32'h0300_3F07;
    localparam logic [DATA_W-1:0] ID_WORD  = {16'h0000, CLUSTER_ID, 8'(CORE_IDX)};

    logic coh_en_q;
    sel_t sel_q;

    // Register updates for the writable per-core locations
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coh_en_q <= 1'b0;
            sel_q    <= '0;
        end else if (wr_stb) begin
            if (ofs == OFS_COH) coh_en_q <= wr_data[0];
            if (ofs == OFS_SEL) sel_q    <= sel_t'(wr_data & SEL_MASK);
        end
    end

    // Read value for the offset presented this cycle
    always_comb begin
        case (ofs)
            OFS_COH: rd_val = {31'b0, coh_en_q};
            OFS_SEL: rd_val = DATA_W'(sel_q);
            OFS_ID:  rd_val = ID_WORD;
            default: rd_val = '0;
        endcase
    end

    assign sel_blk  = sel_q.blk;
    assign sel_core = sel_q.core;
endmodule

// File: rtl/cfgsp_global_regs.sv
// Module: global register bank.
// Offset 0x000 is a read-only core count; offset 0x008 is a free control word.
// Assumes wr_stb is already qualified for the global bank.
module cfgsp_global_regs
    import cfgsp_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_stb,
    input  logic [WIN_OFS_W-1:0] ofs,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [DATA_W-1:0]    rd_val
);
    localparam logic [DATA_W-1:0] INFO_WORD = {24'h0, 8'(NUM_CORES)};

    logic [DATA_W-1:0] ctl_q;

    // Control word update
    always_ff @(posedge clk) begin
        if (!rst_n)                         ctl_q <= '0;
        else if (wr_stb && ofs == OFS_GCTL) ctl_q <= wr_data;
    end

    // Read value for the offset presented this cycle
    always_comb begin
        case (ofs)
            OFS_GINFO: rd_val = INFO_WORD;
            OFS_GCTL:  rd_val = ctl_q;
            default:   rd_val = '0;
        endcase
    end
endmodule

// File: rtl/cfg_redirect_space.sv
// Module: top of the redirected configuration register space.
// Picks the requester's selector, decodes the window, steers writes to one
// bank and registers the read result. Assumes core_id is valid whenever an
// access is presented; an out-of-range core_id reaches no per-core bank.
module cfg_redirect_space
    import cfgsp_pkg::*;
#(
    parameter int         NUM_CORES  = 4,
    parameter logic [7:0] CLUSTER_ID = 8'h03
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CORE_SEL_W-1:0] core_id,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  wr_en,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [DATA_W-1:0]     rd_data
);
    logic [WIN_OFS_W-1:0]  ofs;
    logic [DATA_W-1:0]     core_rd [NUM_CORES];
    blk_e                  bank_blk [NUM_CORES];
    logic [CORE_SEL_W-1:0] bank_core [NUM_CORES];
    blk_e                  req_blk;
    logic [CORE_SEL_W-1:0] req_core;
    tgt_e                  tgt;
    logic [CORE_SEL_W-1:0] tgt_core;
    logic [DATA_W-1:0]     glb_rd;
    logic [DATA_W-1:0]     core_rd_sel;
    logic [DATA_W-1:0]     rd_next;
    logic [DATA_W-1:0]     rd_q;

    assign ofs = addr[WIN_OFS_W-1:0];

    // Select the requester's own selector fields
    always_comb begin
        req_blk  = BLK_CORE;
        req_core = '0;
        for (int i = 0; i < NUM_CORES; i++) begin
            if (core_id == CORE_SEL_W'(i)) begin
                req_blk  = bank_blk[i];
                req_core = bank_core[i];
            end
        end
    end

    cfgsp_win_decode #(.NUM_CORES(NUM_CORES)) i_decode (
        .addr     (addr),
        .core_id  (core_id),
        .req_blk  (req_blk),
        .req_core (req_core),
        .tgt      (tgt),
        .tgt_core (tgt_core)
    );

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
        logic hit;
        assign hit = wr_en && (tgt == TGT_CORE) && (tgt_core == CORE_SEL_W'(g));
        cfgsp_core_regs #(.CORE_IDX(g), .CLUSTER_ID(CLUSTER_ID)) i_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_stb   (hit),
            .ofs      (ofs),
            .wr_data  (wr_data),
            .rd_val   (core_rd[g]),
            .sel_blk  (bank_blk[g]),
            .sel_core (bank_core[g])
        );
    end

    cfgsp_global_regs #(.NUM_CORES(NUM_CORES)) i_global (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_en && (tgt == TGT_GLOBAL)),
        .ofs     (ofs),
        .wr_data (wr_data),
        .rd_val  (glb_rd)
    );

    // Choose the read value of the targeted bank
    always_comb begin
        core_rd_sel = '0;
        for (int i = 0; i < NUM_CORES; i++) begin
            if (tgt_core == CORE_SEL_W'(i)) core_rd_sel = core_rd[i];
        end
        case (tgt)
            TGT_CORE:   rd_next = core_rd_sel;
            TGT_GLOBAL: rd_next = glb_rd;
            default:    rd_next = '0;
        endcase
    end

    // Register the read result one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_next;
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/cfg_redirect_space_chk.sv
// Module: property checker for the redirected register space, bound to the top.
// Assumes the top's internal selector fields req_blk and req_core are visible.
module cfg_redirect_space_chk
    import cfgsp_pkg::*;
#(
    parameter int         NUM_CORES  = 4,
    parameter logic [7:0] CLUSTER_ID = 8'h03
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     addr,
    input logic [CORE_SEL_W-1:0] core_id,
    input logic [1:0]            req_blk,
    input logic [CORE_SEL_W-1:0] req_core,
    input logic [DATA_W-1:0]     rd_data
);
    localparam logic [CORE_SEL_W-1:0] NC = CORE_SEL_W'(NUM_CORES);

    logic armed;

    // Marks cycles whose previous edge was already out of reset
    always_ff @(posedge clk) armed <= rst_n;

    AST_RESET_CLEARS_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> rd_data == '0); // R1

    AST_DEBUG_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(addr[14:13] == 2'd3) |-> rd_data == '0); // R3

    AST_ID_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(addr == 15'h2028 && core_id < NC)
        |-> rd_data == {16'h0, CLUSTER_ID, 2'b00, $past(core_id)}); // R4

    AST_SEL_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(addr == 15'h2018) |-> (rd_data & ~32'h0300_3F07) == '0); // R5

    AST_UNIMPL_BLOCK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(addr[14:13] == 2'd2 && req_blk[1]) |-> rd_data == '0); // R8

    AST_BAD_CORE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(addr[14:13] == 2'd2 && req_blk == 2'd0 && req_core >= NC)
        |-> rd_data == '0); // R9
endmodule

bind cfg_redirect_space cfg_redirect_space_chk #(
    .NUM_CORES  (NUM_CORES),
    .CLUSTER_ID (CLUSTER_ID)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .core_id  (core_id),
    .req_blk  (req_blk),
    .req_core (req_core),
    .rd_data  (rd_data)
);

// File: tb/test_cfg_redirect_space.sv
// Bench: vector table walked by one loop, then directed reset and timing cases.
module test_cfg_redirect_space;
    localparam int         NC = 4;
    localparam logic [7:0] CL = 8'h03;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  core_id = '0;
    logic [14:0] addr = 15'h6000;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cfg_redirect_space #(.NUM_CORES(NC), .CLUSTER_ID(CL)) i_cfg_redirect_space (
        .clk(clk), .rst_n(rst_n), .core_id(core_id), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
    );

    typedef struct packed {
        logic [5:0]  cid;
        logic [14:0] adr;
        logic        we;
        logic [31:0] wd;
        logic        chk;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 40;
    localparam vec_t VECS [NV] = '{
        '{6'd0, 15'h2028, 1'b0, 32'h0,        1'b1, 32'h0000_0300, 8'd4},  // R4 id core0
        '{6'd2, 15'h2028, 1'b0, 32'h0,        1'b1, 32'h0000_0302, 8'd4},  // R4 id core2
        '{6'd1, 15'h2008, 1'b1, 32'hFFFF_FFFF, 1'b1, 32'h0,        8'd2},  // R2 pre-write value
        '{6'd1, 15'h2008, 1'b0, 32'h0,        1'b1, 32'h0000_0001, 8'd4},  // R4 coherence bit
        '{6'd0, 15'h2008, 1'b0, 32'h0,        1'b1, 32'h0,        8'd4},  // R4 other core untouched
        '{6'd0, 15'h2018, 1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0,        8'd5},
        '{6'd0, 15'h2018, 1'b0, 32'h0,        1'b1, 32'h0300_3F07, 8'd5},  // R5 field mask
        '{6'd0, 15'h2018, 1'b1, 32'h0000_0100, 1'b0, 32'h0,        8'd6},
        '{6'd0, 15'h4008, 1'b0, 32'h0,        1'b1, 32'h0000_0001, 8'd6},  // R6 read core1
        '{6'd0, 15'h4028, 1'b0, 32'h0,        1'b1, 32'h0000_0301, 8'd6},  // R6 id via redirect
        '{6'd0, 15'h4008, 1'b1, 32'h0,        1'b0, 32'h0,        8'd6},
        '{6'd1, 15'h2008, 1'b0, 32'h0,        1'b1, 32'h0,        8'd6},  // R6 redirected write landed
        '{6'd0, 15'h2008, 1'b1, 32'h0000_0001, 1'b0, 32'h0,        8'd10},
        '{6'd1, 15'h4008, 1'b0, 32'h0,        1'b1, 32'h0000_0001, 8'd10}, // R10 core1 uses own selector
        '{6'd0, 15'h2018, 1'b0, 32'h0,        1'b1, 32'h0000_0100, 8'd10}, // R10
        '{6'd0, 15'h2018, 1'b1, 32'h0100_0000, 1'b0, 32'h0,        8'd7},
        '{6'd0, 15'h4008, 1'b1, 32'hDEAD_BEEF, 1'b0, 32'h0,        8'd7},
        '{6'd2, 15'h0008, 1'b0, 32'h0,        1'b1, 32'hDEAD_BEEF, 8'd7},  // R7 global write via redirect
        '{6'd0, 15'h4000, 1'b0, 32'h0,        1'b1, 32'h0000_0004, 8'd7},  // R7 global read via redirect
        '{6'd0, 15'h0000, 1'b1, 32'h0000_00FF, 1'b1, 32'h0000_0004, 8'd11}, // R11
        '{6'd0, 15'h0000, 1'b0, 32'h0,        1'b1, 32'h0000_0004, 8'd11}, // R11 read-only
        '{6'd0, 15'h0010, 1'b0, 32'h0,        1'b1, 32'h0,        8'd11}, // R11 unimplemented
        '{6'd0, 15'h2018, 1'b1, 32'h0200_0000, 1'b0, 32'h0,        8'd8},
        '{6'd0, 15'h4008, 1'b1, 32'h1234_5678, 1'b1, 32'h0,        8'd8},  // R8 user block
        '{6'd3, 15'h0008, 1'b0, 32'h0,        1'b1, 32'hDEAD_BEEF, 8'd8},  // R8 write ignored
        '{6'd0, 15'h2018, 1'b1, 32'h0300_0000, 1'b0, 32'h0,        8'd8},
        '{6'd0, 15'h4008, 1'b0, 32'h0,        1'b1, 32'h0,        8'd8},  // R8 upper global block
        '{6'd0, 15'h2018, 1'b1, 32'h0000_0500, 1'b0, 32'h0,        8'd9},
        '{6'd0, 15'h4008, 1'b1, 32'h0000_0001, 1'b1, 32'h0,        8'd9},  // R9 core 5 absent
        '{6'd1, 15'h2008, 1'b0, 32'h0,        1'b1, 32'h0,        8'd9},  // R9 no alias write
        '{6'd0, 15'h6008, 1'b1, 32'hFFFF_FFFF, 1'b1, 32'h0,        8'd3},  // R3 debug read
        '{6'd0, 15'h2008, 1'b0, 32'h0,        1'b1, 32'h0000_0001, 8'd3},  // R3 write ignored
        '{6'd0, 15'h6028, 1'b0, 32'h0,        1'b1, 32'h0,        8'd3},  // R3
        '{6'd2, 15'h2028, 1'b1, 32'h0,        1'b1, 32'h0000_0302, 8'd4},  // R4
        '{6'd2, 15'h2028, 1'b0, 32'h0,        1'b1, 32'h0000_0302, 8'd4},  // R4 id read-only
        '{6'd0, 15'h2018, 1'b1, 32'h0000_0300, 1'b0, 32'h0,        8'd6},
        '{6'd0, 15'h4018, 1'b1, 32'h0100_0000, 1'b0, 32'h0,        8'd6},
        '{6'd3, 15'h4000, 1'b0, 32'h0,        1'b1, 32'h0000_0004, 8'd6},  // R6 remote selector write
        '{6'd3, 15'h2018, 1'b0, 32'h0,        1'b1, 32'h0100_0000, 8'd6},  // R6
        '{6'd1, 15'h4018, 1'b0, 32'h0,        1'b1, 32'h0000_0300, 8'd10}  // R10
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: rd_data=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic [5:0] c, input logic [14:0] a, input logic w,
                          input logic [31:0] d);
        @(negedge clk);
        core_id = c; addr = a; wr_en = w; wr_data = d;
        @(posedge clk);
        #1;
        core_id = '0; addr = 15'h6000; wr_en = 1'b0; wr_data = '0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1", rd_data, 32'h0);  // R1 reset value

        // R2: result must not appear before the capturing edge
        @(negedge clk);
        core_id = 6'd0; addr = 15'h2028;
        #1 check("R2", rd_data, 32'h0);
        @(posedge clk);
        #1 addr = 15'h6000;
        @(negedge clk);
        check("R2", rd_data, 32'h0000_0300);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].cid, VECS[i].adr, VECS[i].we, VECS[i].wd);
            if (VECS[i].chk) check($sformatf("R%0d", VECS[i].req), rd_data, VECS[i].exp);
        end

        // R1: mid-run reset clears state
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        access(6'd0, 15'h2008, 1'b0, 32'h0);
        check("R1", rd_data, 32'h0);
        access(6'd3, 15'h2018, 1'b0, 32'h0);
        check("R1", rd_data, 32'h0);
        access(6'd2, 15'h0008, 1'b0, 32'h0);
        check("R1", rd_data, 32'h0);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule